// File: doc/BRIEF.md
# Fixed-Point Narrowing Stage with Selectable Rounding and Overflow

This block takes a wide signed intermediate value, such as the raw output of a multiplier or an adder tree, and narrows it to a signed N-bit Q-format result. It drops the F lowest bits under one of four rounding policies. It then brings the rounded value into the N-bit range under one of three overflow policies. Both policies are chosen per input through two mode selects, so one instance can serve several arithmetic paths that need different behaviour.

The stage is registered and takes one cycle. Each accepted input gives exactly one output a cycle later. A free-running linear feedback shift register supplies the random bits for stochastic rounding. It advances once for every accepted input, whatever the mode. In trap mode an out-of-range result is saturated and raises a sticky error flag, which only reset clears. Widths are parameters. The default narrows a 32-bit value to a 16-bit output with 8 fraction bits dropped. Formats such as 16 bits with 12 fraction bits, or 32 bits with 16, come from other parameter values.

Top module: `fxn_narrow`

## Requirements
- R1: One cycle after a cycle with `inValid` high, `outValid` is high and `outData` holds that input's result. After a cycle with `inValid` low, `outValid` is low and `outData` keeps its previous value, whatever `inData` is. After reset, `outValid`, `outData` and `trapError` are all zero.
- R2: With `roundMode` = 0 (truncate), the rounded value is floor(in / 2^F), an arithmetic right shift by F.
- R3: With `roundMode` = 1 (nearest), the rounded value is floor((in + 2^(F-1)) / 2^F), so exact halves round upward.
- R4: With `roundMode` = 2 (half-to-even), the value rounds up when the dropped bits exceed one half. It also rounds up at exactly one half when the truncated value is odd. Otherwise it truncates.
- R5: With `roundMode` = 3 (stochastic), the value rounds up exactly when the F dropped bits, read as an unsigned number, are greater than bits F-1..0 of the 16-bit random register. That register loads 0xACE1 on reset. On every accepted input it shifts up by one bit, and its new bit 0 is the XOR of its old bits 15, 13, 12 and 10. An input uses the register value from before its own advance.
- R6: With `ovfMode` = 0 (saturate), or with the unused code 3, a rounded value above 2^(N-1)-1 gives 2^(N-1)-1, and one below -2^(N-1) gives -2^(N-1). In-range values pass unchanged.
- R7: With `ovfMode` = 1 (wrap), the output is the low N bits of the rounded value.
- R8: With `ovfMode` = 2 (trap), the output saturates as in R6. An out-of-range result sets `trapError` in the same cycle as that output, and the flag stays set until reset. In-range results in trap mode do not set it.
- R9: The overflow policy acts on the value after rounding. A round-up carry that pushes a value past the maximum counts as overflow.
- R10: `trapError` is never set by an input accepted with `ovfMode` other than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Accepts `inData` in this cycle |
| inData | input | IN_W | Wide signed input value |
| roundMode | input | 2 | 0 truncate, 1 nearest, 2 half-to-even, 3 stochastic |
| ovfMode | input | 2 | 0 saturate, 1 wrap, 2 trap, 3 saturate |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| outData | output | OUT_W | Narrowed signed result |
| trapError | output | 1 | Sticky flag for an out-of-range result in trap mode |

## Verification
Rounding and overflow can act on the same input. A value whose integer part already sits at the maximum can carry past it when the dropped bits round up. The bench provokes this with directed inputs at the positive edge of the range, with the dropped bits at and above one half. It applies them in truncate, nearest and half-to-even modes under the saturate, wrap and trap policies. Each case is judged on the output value and on the trap flag: truncation must leave the flag clear, and a round-up carry must saturate, wrap or trap as its mode requires.

// File: rtl/fxn_narrow_pkg.sv
package fxn_narrow_pkg;

  typedef enum logic [1:0] {
    RND_TRUNC  = 2'd0,
    RND_NEAR   = 2'd1,
    RND_EVEN   = 2'd2,
    RND_STOCH  = 2'd3
  } roundMode_e;

  typedef enum logic [1:0] {
    OVF_SAT    = 2'd0,
    OVF_WRAP   = 2'd1,
    OVF_TRAP   = 2'd2,
    OVF_SAT_ALT = 2'd3
  } ovfMode_e;

  // Strobes from control to datapath and random source
  typedef struct packed {
    logic loadOut;
    logic stepLfsr;
    logic raiseTrap;
  } ctrlStrobes_t;

endpackage

// File: rtl/fxn_lfsr.sv
module fxn_lfsr #(
  parameter int          W     = 16,
  parameter int          OUT_B = 8,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [OUT_B-1:0] rndBits
);

  logic [W-1:0] state;
  logic         feedBit;

  assign feedBit = ^(state & TAPS);
  assign rndBits = state[OUT_B-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEED;
    end else if (step) begin
      state <= {state[W-2:0], feedBit};
    end
  end

endmodule

// File: rtl/fxn_ctrl.sv
module fxn_ctrl
  import fxn_narrow_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  ovfMode_e     ovfSel,
  input  logic         ovfHit,
  output ctrlStrobes_t strobes,
  output logic         outValid,
  output logic         trapError
);

  always_comb begin
    strobes.loadOut   = inValid;
    strobes.stepLfsr  = inValid;
    strobes.raiseTrap = inValid && (ovfSel == OVF_TRAP) && ovfHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      trapError <= 1'b0;
    end else begin
      outValid <= inValid;
      if (strobes.raiseTrap) begin
        trapError <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fxn_datapath.sv
module fxn_datapath
  import fxn_narrow_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16,
  parameter int FRAC  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic [IN_W-1:0]  inData,
  input  roundMode_e       roundSel,
  input  ovfMode_e         ovfSel,
  input  logic [FRAC-1:0]  rndBits,
  output logic             ovfHit,
  output logic [OUT_W-1:0] outData
);

  localparam int SHW = IN_W - FRAC;
  localparam int RW  = SHW + 1;
  localparam int unsigned HALF_I = 1 << (FRAC - 1);
  localparam logic [FRAC-1:0] HALF = HALF_I[FRAC-1:0];
  localparam logic signed [RW-1:0] OUT_MAX = {{(RW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [RW-1:0] OUT_MIN = {{(RW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic [SHW-1:0]         shifted;
  logic [FRAC-1:0]        dropBits;
  logic                   roundUp;
  logic signed [RW-1:0]   rounded;
  logic [OUT_W-1:0]       clampVal;
  logic [OUT_W-1:0]       narrowed;
  logic                   tooHigh;
  logic                   tooLow;

  assign shifted  = inData[IN_W-1:FRAC];
  assign dropBits = inData[FRAC-1:0];

  // Rounding decision
  always_comb begin
    unique case (roundSel)
      RND_TRUNC: roundUp = 1'b0;
      RND_NEAR:  roundUp = (dropBits >= HALF);
      RND_EVEN:  roundUp = (dropBits > HALF) || ((dropBits == HALF) && shifted[0]);
      RND_STOCH: roundUp = (dropBits > rndBits);
      default:   roundUp = 1'b0;
    endcase
  end

  assign rounded = $signed({shifted[SHW-1], shifted}) + $signed({{(RW-1){1'b0}}, roundUp});

  // Overflow handling on the rounded value
  assign tooHigh = (rounded > OUT_MAX);
  assign tooLow  = (rounded < OUT_MIN);
  assign ovfHit  = tooHigh || tooLow;

  always_comb begin
    if (tooHigh) begin
      clampVal = OUT_MAX[OUT_W-1:0];
    end else if (tooLow) begin
      clampVal = OUT_MIN[OUT_W-1:0];
    end else begin
      clampVal = rounded[OUT_W-1:0];
    end
  end

  assign narrowed = (ovfSel == OVF_WRAP) ? rounded[OUT_W-1:0] : clampVal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outData <= '0;
    end else if (strobes.loadOut) begin
      outData <= narrowed;
    end
  end

endmodule

// File: rtl/fxn_narrow.sv
module fxn_narrow
  import fxn_narrow_pkg::*;
#(
  parameter int          IN_W      = 32,
  parameter int          OUT_W     = 16,
  parameter int          FRAC      = 8,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS = 16'hB400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  input  logic [1:0]       roundMode,
  input  logic [1:0]       ovfMode,
  output logic             outValid,
  output logic [OUT_W-1:0] outData,
  output logic             trapError
);

  ctrlStrobes_t    strobes;
  logic            ovfHit;
  logic [FRAC-1:0] rndBits;
  roundMode_e      roundSel;
  ovfMode_e        ovfSel;

  assign roundSel = roundMode_e'(roundMode);
  assign ovfSel   = ovfMode_e'(ovfMode);

  fxn_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .ovfSel    (ovfSel),
    .ovfHit    (ovfHit),
    .strobes   (strobes),
    .outValid  (outValid),
    .trapError (trapError)
  );

  fxn_lfsr #(
    .W     (LFSR_W),
    .OUT_B (FRAC),
    .SEED  (LFSR_SEED[LFSR_W-1:0]),
    .TAPS  (LFSR_TAPS[LFSR_W-1:0])
  ) lfsr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (strobes.stepLfsr),
    .rndBits (rndBits)
  );

  fxn_datapath #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W),
    .FRAC  (FRAC)
  ) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .inData   (inData),
    .roundSel (roundSel),
    .ovfSel   (ovfSel),
    .rndBits  (rndBits),
    .ovfHit   (ovfHit),
    .outData  (outData)
  );

endmodule

// File: rtl/fxn_narrow_chk.sv
module fxn_narrow_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic [1:0]       ovfMode,
  input logic             outValid,
  input logic [OUT_W-1:0] outData,
  input logic             trapError
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(outData));

  assert_trap_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trapError |=> trapError);

  assert_trap_with_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trapError) |-> outValid);

  assert_no_trap_other_modes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!trapError && !(inValid && ovfMode == 2'd2)) |=> !trapError);

endmodule

bind fxn_narrow fxn_narrow_chk #(.OUT_W(OUT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .inValid   (inValid),
  .ovfMode   (ovfMode),
  .outValid  (outValid),
  .outData   (outData),
  .trapError (trapError)
);

// File: tb/fxn_narrow_tb_top.sv
module fxn_narrow_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] inData = '0;
  logic [1:0]  roundMode = '0;
  logic [1:0]  ovfMode = '0;
  logic        outValid;
  logic [15:0] outData;
  logic        trapError;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [15:0] modelLfsr = 16'hACE1;
  bit expTrap = 1'b0;

  always #10 clk = ~clk;

  fxn_narrow dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .inData    (inData),
    .roundMode (roundMode),
    .ovfMode   (ovfMode),
    .outValid  (outValid),
    .outData   (outData),
    .trapError (trapError)
  );

  function automatic logic [15:0] lfsrNext(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic void model(input logic [31:0] d, input logic [1:0] rm,
                                input logic [1:0] om, input logic [15:0] lf,
                                output logic [15:0] res, output bit ovf);
    longint v = longint'($signed(d));
    longint sh = v >>> 8;
    longint fr = v & 255;
    longint r;
    bit up;
    case (rm)
      2'd0: up = 1'b0;
      2'd1: up = (fr >= 128);
      2'd2: up = (fr > 128) || (fr == 128 && sh[0]);
      default: up = (fr > longint'(lf[7:0]));
    endcase
    r = sh + (up ? 1 : 0);
    ovf = (r > 32767) || (r < -32768);
    if (om == 2'd1) res = r[15:0];
    else if (r > 32767) res = 16'h7FFF;
    else if (r < -32768) res = 16'h8000;
    else res = r[15:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    modelLfsr = 16'hACE1;
    expTrap = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, input logic [1:0] rm,
                      input logic [1:0] om, input string req);
    logic [15:0] e;
    bit ovf;
    @(negedge clk);
    inValid = 1'b1;
    inData = d;
    roundMode = rm;
    ovfMode = om;
    model(d, rm, om, modelLfsr, e, ovf);
    modelLfsr = lfsrNext(modelLfsr);
    if (om == 2'd2 && ovf) expTrap = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    inData = $urandom;
    check(outValid == 1'b1, "R1", outValid, 1);
    check(outData == e, req, outData, e);
    check(trapError == expTrap, (om == 2'd2) ? "R8" : "R10", trapError, expTrap);
  endtask

  task automatic idleCheck();
    logic [15:0] held;
    held = outData;
    @(negedge clk);
    inData = $urandom;
    roundMode = 2'($urandom);
    check(outValid == 1'b0, "R1 idle valid", outValid, 0);
    check(outData == held, "R1 idle hold", outData, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    @(negedge clk);
    check(outValid == 1'b0, "R1 reset valid", outValid, 0);
    check(outData == 16'h0, "R1 reset data", outData, 0);
    check(trapError == 1'b0, "R1 reset trap", trapError, 0);

    // Truncate
    push(32'hFFFF_FFFF, 2'd0, 2'd0, "R2 trunc -1/256");
    push(32'h0000_01FF, 2'd0, 2'd0, "R2 trunc 1.996");
    idleCheck();
    // Nearest
    push(32'hFFFF_FFFF, 2'd1, 2'd0, "R3 near -1/256");
    push(32'hFFFF_FE80, 2'd1, 2'd0, "R3 near -1.5");
    push(32'h0000_0180, 2'd1, 2'd0, "R3 near 1.5");
    // Half-to-even
    push(32'h0000_0180, 2'd2, 2'd0, "R4 even 1.5");
    push(32'h0000_0280, 2'd2, 2'd0, "R4 even 2.5");
    push(32'h0000_0281, 2'd2, 2'd0, "R4 even 2.5+");
    push(32'hFFFF_FE80, 2'd2, 2'd0, "R4 even -1.5");
    // Stochastic
    push(32'h0000_0300, 2'd3, 2'd0, "R5 stoch zero frac");
    push(32'h0000_03FF, 2'd3, 2'd0, "R5 stoch max frac");
    push(32'h0000_0340, 2'd3, 2'd0, "R5 stoch mid");
    push(32'h0000_03C0, 2'd3, 2'd0, "R5 stoch high");
    // Saturate and alternate code
    push(32'h7FFF_FFFF, 2'd0, 2'd0, "R6 sat high");
    push(32'h8000_0000, 2'd0, 2'd3, "R6 sat low alt");
    // Wrap
    push(32'h0080_0000, 2'd0, 2'd1, "R7 wrap 32768");
    push(32'hFF7F_FF00, 2'd0, 2'd1, "R7 wrap -32769");
    // Rounding carry into overflow
    push(32'h007F_FF80, 2'd0, 2'd2, "R9 trunc at max no trap");
    push(32'h007F_FF80, 2'd1, 2'd0, "R9 near carry sat");
    push(32'h007F_FF80, 2'd1, 2'd1, "R9 near carry wrap");
    push(32'h007F_FF81, 2'd2, 2'd1, "R9 even carry wrap");
    push(32'hFF80_0000, 2'd1, 2'd2, "R8 trap min in range");
    push(32'h007F_FF80, 2'd1, 2'd2, "R9 near carry trap");
    push(32'h0000_0100, 2'd0, 2'd0, "R8 sticky");
    idleCheck();
    doReset();
    @(negedge clk);
    check(trapError == 1'b0, "R8 cleared by reset", trapError, 0);

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      logic [1:0] rm;
      logic [1:0] om;
      string req;
      d = $urandom;
      if ($urandom % 2 == 0) d = {{8{d[23]}}, d[23:0]};
      rm = 2'($urandom);
      om = 2'($urandom);
      case (rm)
        2'd0: req = "R2 random";
        2'd1: req = "R3 random";
        2'd2: req = "R4 random";
        default: req = "R5 random";
      endcase
      push(d, rm, om, req);
      if ($urandom % 8 == 0) idleCheck();
    end

    finishRun();
  end

endmodule